// File: doc/BRIEF.md
# Clocked Synchronous Serial Channel

This block is a full-duplex serial channel in which every data bit is framed by a shift clock instead of start and stop bits. Characters are always eight bits, sent least significant bit first, with no parity or framing bits. In master mode the block generates the shift clock from the system clock through an internal divider and drives it out. In slave mode it shifts on a shift clock supplied from outside, which it passes through a two-stage synchroniser before detecting edges.

The host side is a simple register-style interface. A write strobe loads a transmit holding register, and a read strobe takes a byte from a receive holding register. Both directions are double-buffered. The host can therefore stage the next byte while the current one is still shifting, and in master mode consecutive bytes then follow with no pause in the clock. The only receive error is overrun. When a byte completes while the previous one is still unread, the older byte is kept, the new byte is discarded, and a flag is raised. Reception of later bytes carries on.

Top module: `sync_serial_chan`

## Requirements
- R1: After reset, `sck_o` is 1, `sdo` is 1, `tx_empty` is 1, `rx_full` is 0 and `rx_ovr` is 0.
- R2: In master mode (`ext_sel`=0), `sck_oe` is 1. `sck_o` stays high with no edges while the transmit holding register is empty and no byte is being shifted.
- R3: In master mode, each low phase and each high phase of `sck_o` lasts exactly HALF_DIV system clock cycles while bytes are streaming.
- R4: `sdo` changes only together with a falling edge of the shift clock, and `sdi` is sampled on the rising edge. Bits are sent and received least significant bit first, eight per byte, with no other bits in between.
- R5: In master mode, if the transmit holding register is full when a byte's eighth rising edge occurs, the next falling edge follows exactly HALF_DIV cycles later, with no idle clock period.
- R6: A write (`tx_wr`=1) is accepted only while `tx_empty` is 1. A write while the holding register is full is ignored, and the earlier byte is the one transmitted.
- R7: In slave mode (`ext_sel`=1), `sck_oe` is 0 and shifting follows the edges of `sck_i`. If the holding register is empty when a byte starts, the byte sent is 8'hFF.
- R8: A completed received byte is placed on `rx_data` with `rx_full`=1. While `rx_full` is 1 and no read occurs, `rx_data` and `rx_full` do not change.
- R9: If a byte completes while `rx_full` is 1 and no read occurs in that cycle, `rx_ovr` is set, the older byte stays on `rx_data`, the new byte is discarded, and later bytes are still received.
- R10: A read (`rx_rd`=1 while `rx_full`=1) clears both `rx_full` and `rx_ovr` in the next cycle, unless a new byte completes in that same cycle. In that case the new byte is stored and `rx_ovr` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | 1 = shift on external clock (slave), 0 = internal divider (master) |
| sck_i | input | 1 | External shift clock, asynchronous to `clk` |
| sck_o | output | 1 | Generated shift clock, idles high |
| sck_oe | output | 1 | Output enable for the shift clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_wr | input | 1 | Host write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register can take a byte |
| rx_rd | input | 1 | Host read strobe for the receive holding register |
| rx_data | output | 8 | Oldest unread received byte |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| rx_ovr | output | 1 | A received byte was dropped because the holding register was full |

## Verification
If the bit index or the in-byte state goes wrong, the serial output shows it within one byte. In master loopback the rebuilt byte is wrong, the clock stalls between bytes, or the clock runs without a staged byte. A slipped divider count shows up at the very next shift clock edge as a half-period of the wrong length. Errors in the receive holding logic show up at the first host read after the fault: a byte is overwritten during overrun, the flag fails to clear, or a byte is lost after the flag has been set. In slave mode, a wrong start-of-byte decision shows up in the first sampled byte as the wrong staged byte or a missing all-ones fill.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int SYNC_N    = 2;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ssc_edge_gen.sv
module ssc_edge_gen
  import ssc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic run_ok,
  input  logic sck_i,
  output logic sck_o,
  output logic fall_p,
  output logic rise_p
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             m_fall, m_rise;
  logic [SYNC_N:0]  sync_q;
  logic             x_fall, x_rise;

  // internal divider: a falling edge is only issued from the idle-high point
  always_comb begin
    cnt_d  = cnt_q;
    sck_d  = sck_q;
    m_fall = 1'b0;
    m_rise = 1'b0;
    if (!ext_sel) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_W'(1);
      end else if (!sck_q) begin
        sck_d  = 1'b1;
        m_rise = 1'b1;
        cnt_d  = CNT_W'(HALF_DIV - 1);
      end else if (run_ok) begin
        sck_d  = 1'b0;
        m_fall = 1'b1;
        cnt_d  = CNT_W'(HALF_DIV - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  // external clock: sync_q[0..SYNC_N-1] synchronise, sync_q[SYNC_N] is the previous level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_N-1:0], sck_i};
    end
  end

  assign x_fall = sync_q[SYNC_N] & ~sync_q[SYNC_N-1];
  assign x_rise = ~sync_q[SYNC_N] & sync_q[SYNC_N-1];

  assign sck_o  = sck_q;
  assign fall_p = ext_sel ? x_fall : m_fall;
  assign rise_p = ext_sel ? x_rise : m_rise;
endmodule

// File: rtl/ssc_tx.sv
module ssc_tx
  import ssc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  byte_t wr_data,
  input  logic  fall_p,
  input  logic  rise_p,
  output logic  tx_empty,
  output logic  in_byte,
  output logic  byte_end,
  output logic  sdo,
  output byte_t hold_o
);
  localparam logic [BIT_IDX_W-1:0] LAST = BIT_IDX_W'(BYTE_W - 1);

  byte_t                hold_q, hold_d;
  byte_t                sh_q, sh_d;
  logic                 full_q, full_d;
  logic                 act_q, act_d;
  logic [BIT_IDX_W-1:0] idx_q, idx_d;
  logic                 accept, start;

  assign accept   = wr & ~full_q;
  assign start    = fall_p & ~act_q;
  assign byte_end = rise_p & act_q & (idx_q == LAST);

  always_comb begin
    hold_d = accept ? wr_data : hold_q;
    full_d = full_q;
    if (start)  full_d = 1'b0;
    if (accept) full_d = 1'b1;
    sh_d  = sh_q;
    idx_d = idx_q;
    act_d = act_q;
    if (start) begin
      sh_d  = full_q ? hold_q : '1;
      idx_d = '0;
      act_d = 1'b1;
    end else if (fall_p && act_q) begin
      sh_d  = {1'b1, sh_q[BYTE_W-1:1]};
      idx_d = idx_q + BIT_IDX_W'(1);
    end
    if (byte_end) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      act_q  <= act_d;
    end
  end

  assign tx_empty = ~full_q;
  assign in_byte  = act_q;
  assign sdo      = sh_q[0];
  assign hold_o   = hold_q;
endmodule

// File: rtl/ssc_rx.sv
module ssc_rx
  import ssc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sdi,
  input  logic  rise_p,
  input  logic  byte_end,
  input  logic  rd,
  output byte_t rx_data,
  output logic  rx_full,
  output logic  rx_ovr
);
  byte_t sh_q, sh_d, hold_q, hold_d;
  logic  full_q, full_d, ovr_q, ovr_d;
  logic  take, still_full;

  assign take       = rd & full_q;
  assign still_full = full_q & ~take;

  always_comb begin
    sh_d   = rise_p ? {sdi, sh_q[BYTE_W-1:1]} : sh_q;
    hold_d = hold_q;
    full_d = still_full;
    ovr_d  = ovr_q & ~take;
    if (byte_end) begin
      if (still_full) begin
        ovr_d = 1'b1;
      end else begin
        hold_d = sh_d;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      hold_q <= hold_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_data = hold_q;
  assign rx_full = full_q;
  assign rx_ovr  = ovr_q;
endmodule

// File: rtl/sync_serial_chan.sv
module sync_serial_chan
  import ssc_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_sel,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  output logic       tx_empty,
  input  logic       rx_rd,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       rx_ovr
);
  logic  fall_p, rise_p, in_byte, byte_end, run_ok;
  byte_t tx_hold;

  assign run_ok = in_byte | ~tx_empty;
  assign sck_oe = ~ext_sel;

  ssc_edge_gen #(.HALF_DIV(HALF_DIV)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ext_sel(ext_sel),
    .run_ok (run_ok),
    .sck_i  (sck_i),
    .sck_o  (sck_o),
    .fall_p (fall_p),
    .rise_p (rise_p)
  );

  ssc_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (tx_wr),
    .wr_data (tx_data),
    .fall_p  (fall_p),
    .rise_p  (rise_p),
    .tx_empty(tx_empty),
    .in_byte (in_byte),
    .byte_end(byte_end),
    .sdo     (sdo),
    .hold_o  (tx_hold)
  );

  ssc_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdi     (sdi),
    .rise_p  (rise_p),
    .byte_end(byte_end),
    .rd      (rx_rd),
    .rx_data (rx_data),
    .rx_full (rx_full),
    .rx_ovr  (rx_ovr)
  );
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int HALF_DIV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_sel,
  input logic       sck_o,
  input logic       sdo,
  input logic       tx_empty,
  input logic       in_byte,
  input logic [7:0] tx_hold,
  input logic       rx_rd,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       rx_ovr
);
  localparam int RW = $clog2(HALF_DIV + 1) + 1;

  logic          sck_d;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b1;
      run_len <= RW'(HALF_DIV);
    end else begin
      sck_d <= sck_o;
      if (sck_o != sck_d) run_len <= RW'(1);
      else if (run_len < RW'(HALF_DIV)) run_len <= run_len + RW'(1);
    end
  end

  // R2
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && !in_byte && tx_empty) |-> sck_o);

  // R3
  half_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && sck_o != sck_d) |-> run_len == RW'(HALF_DIV));

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && sck_o) |=> (!sck_o || $stable(sdo)));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |=> $stable(tx_hold));

  // R8
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));

  // R9
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> rx_full);

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_rd) |=> !rx_ovr);
endmodule

bind sync_serial_chan ssc_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ext_sel (ext_sel),
  .sck_o   (sck_o),
  .sdo     (sdo),
  .tx_empty(tx_empty),
  .in_byte (in_byte),
  .tx_hold (tx_hold),
  .rx_rd   (rx_rd),
  .rx_data (rx_data),
  .rx_full (rx_full),
  .rx_ovr  (rx_ovr)
);

// File: tb/sim_sync_serial_chan.sv
module sim_sync_serial_chan;
  localparam int HALF = 4;
  localparam int SH   = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       ext_sel = 1'b0, sck_i = 1'b1, bsdi = 1'b1, lb = 1'b1;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  wire        sck_o, sck_oe, sdo, tx_empty, rx_full, rx_ovr;
  wire  [7:0] rx_data;
  wire        sdi = lb ? sdo : bsdi;

  sync_serial_chan #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr)
  );

  int checks = 0, errs = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // shift clock monitor for master streaming
  bit mon_on = 1'b0, have_edge = 1'b0;
  logic sck_prev = 1'b1;
  logic [7:0] obs = 8'h00;
  int last_edge = 0, gap_err = 0, nbits = 0, nbytes = 0;
  always @(negedge clk) begin
    if (mon_on && sck_o !== sck_prev) begin
      if (have_edge && (cyc - last_edge) != HALF) gap_err++;
      have_edge = 1'b1;
      last_edge = cyc;
      if (sck_o === 1'b1) begin
        obs = {sdo, obs[7:1]};
        nbits++;
        if (nbits % 8 == 0) begin
          chk(obs == nbytes[7:0], "R4 lsb-first byte on sdo", obs, nbytes[7:0]);
          nbytes++;
        end
      end
    end
    sck_prev = sck_o;
  end

  task automatic host_write(input logic [7:0] v);
    while (tx_empty !== 1'b1) @(negedge clk);
    tx_data = v; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic host_read();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic slave_byte(input logic [7:0] din, output logic [7:0] dout);
    dout = 8'h00;
    for (int b = 0; b < 8; b++) begin
      sck_i = 1'b0; bsdi = din[b];
      repeat (SH) @(negedge clk);
      dout[b] = sdo;
      sck_i = 1'b1;
      repeat (SH) @(negedge clk);
    end
  endtask

  task automatic idle_check(input string tag);
    int lows = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sck_o !== 1'b1) lows++;
    end
    chk(lows == 0, tag, lows, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    logic [7:0] got, a, din;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sck_o === 1'b1, "R1 sck_o", sck_o, 1);
    chk(sdo === 1'b1, "R1 sdo", sdo, 1);
    chk(tx_empty === 1'b1, "R1 tx_empty", tx_empty, 1);
    chk(rx_full === 1'b0, "R1 rx_full", rx_full, 0);
    chk(rx_ovr === 1'b0, "R1 rx_ovr", rx_ovr, 0);
    // R2 master idle
    chk(sck_oe === 1'b1, "R2 sck_oe master", sck_oe, 1);
    idle_check("R2 idle clock before stream");

    // full sweep of byte values in loopback, host keeps both buffers serviced
    have_edge = 1'b0; mon_on = 1'b1;
    fork
      begin
        for (int i = 0; i < 256; i++) host_write(i[7:0]);
      end
      begin
        for (int j = 0; j < 256; j++) begin
          while (rx_full !== 1'b1) @(negedge clk);
          chk(rx_data == j[7:0], "R8 loopback byte", rx_data, j[7:0]);
          chk(rx_ovr === 1'b0, "R9 no overrun when read in time", rx_ovr, 0);
          host_read();
        end
      end
    join
    mon_on = 1'b0;
    chk(gap_err == 0, "R3 R5 half periods uniform across bytes", gap_err, 0);
    chk(nbytes == 256, "R4 byte count on sdo", nbytes, 256);
    idle_check("R2 idle clock after stream");

    // overrun: three bytes, no reads
    host_write(8'hA5);
    host_write(8'h3C);
    host_write(8'hE1);
    repeat (200) @(negedge clk);
    chk(rx_full === 1'b1, "R8 rx_full held", rx_full, 1);
    chk(rx_data == 8'hA5, "R9 oldest byte kept", rx_data, 8'hA5);
    chk(rx_ovr === 1'b1, "R9 overrun flagged", rx_ovr, 1);
    host_read();
    chk(rx_full === 1'b0, "R10 read clears full", rx_full, 0);
    chk(rx_ovr === 1'b0, "R10 read clears overrun", rx_ovr, 0);
    host_write(8'h96);
    repeat (120) @(negedge clk);
    chk(rx_full === 1'b1 && rx_data == 8'h96, "R9 reception continues", rx_data, 8'h96);
    chk(rx_ovr === 1'b0, "R9 no stale overrun", rx_ovr, 0);
    host_read();

    // slave mode sweep
    lb = 1'b0; ext_sel = 1'b1;
    @(negedge clk);
    chk(sck_oe === 1'b0, "R7 sck_oe slave", sck_oe, 0);
    for (int v = 0; v < 16; v++) begin
      a   = 8'(v * 17) ^ 8'h5A;
      din = 8'(v * 13 + 7);
      host_write(a);
      tx_data = ~a; tx_wr = 1'b1;
      @(negedge clk);
      tx_wr = 1'b0;
      chk(tx_empty === 1'b0, "R6 holding stays full", tx_empty, 0);
      slave_byte(din, got);
      chk(got == a, "R6 R7 first staged byte sent", got, a);
      chk(rx_full === 1'b1 && rx_data == din, "R7 slave receive", rx_data, din);
      chk(tx_empty === 1'b1, "R7 holding drained", tx_empty, 1);
      host_read();
    end
    slave_byte(8'hC3, got);
    chk(got == 8'hFF, "R7 empty holding sends ones", got, 8'hFF);
    chk(rx_data == 8'hC3, "R7 receive during underrun", rx_data, 8'hC3);
    host_read();

    finish_run();
  end
endmodule